// File: doc/BRIEF.md
# Interval Pulse Timer

This block counts ticks from a 32.768 kHz prescaler strobe and drives an active-low pin. The pin carries a pulse one tick wide each time a selected interval ends. The interval can be a tenth of a second, one second, ten seconds, thirty seconds or sixty seconds.

The tenth-of-a-second setting cannot divide a half second evenly. It therefore uses interval lengths that differ by one tick, chosen so that every group of five adds up to exactly half a second. A sticky flag records each interval end, and software clears it with a write. In repeat mode the timer runs on without end. In one-shot mode it fires once after a restart and then holds.

Software can halt the count and resume it later without losing the part of the interval already counted. It can also restart the count from zero and mute the pin. The pin can also show an external busy level instead of the timer pulses.

Software reaches the block through one 4-bit write port with a one-bit register select. Select 0 is the mode register: bits [2:0] hold the period code and bit 3 selects one-shot. Select 1 is the command register: bit 0 halts, bit 1 restarts, bit 2 mutes and bit 3 clears the flag.

Top module: `interval_pulse_timer`

## Requirements
- R1: After reset the pin is high and the flag is low. The timer is running in repeat mode with period code 000 and the pin unmuted.
- R2: Period code 001 gives intervals of TICKS_PER_SEC ticks. Code 010 gives ten times that, 011 thirty times and 100 sixty times. Codes 101 and 110 produce no pulses and never set the flag.
- R3: With period code 000, interval k of each group of five (k = 1..5) ends H*k/5 ticks after the group starts, rounded down, where H = TICKS_PER_SEC/2. The five lengths add up to exactly H. For H = 22 the intervals are 4, 4, 5, 4 and 5 ticks.
- R4: The pin goes low in the clock after the tick edge that ends an interval. It stays low for exactly one tick period and returns high after the next tick edge.
- R5: With mode bit 3 = 0 the timer repeats: pulses keep coming at the selected period.
- R6: With mode bit 3 = 1 the timer gives exactly one pulse after a restart. It then gives no further pulses or flag sets until the next restart.
- R7: While the halt bit (command bit 0) is 1, ticks are not counted. After a halt of t1 into an interval, the next pulse comes t2 counted ticks after resume, where t1 + t2 equals the period.
- R8: A command write with bit 1 set restarts the count. Whatever it interrupts, the next pulse comes one full period of ticks after the write edge, and the write also releases a one-shot hold.
- R9: While the mute bit (command bit 2) is 1, the pin stays high. Counting and the flag carry on unchanged.
- R10: The flag is set at every interval end and stays set until a command write with bit 3 set clears it. If an interval ends on the same edge as a clear, the set wins.
- R11: When mode bits [2:0] = 111, the pin shows the inverse of busyIn in the same cycle (unless muted), and the flag is never set.
- R12: Mode, halt and mute values are registered at the write edge and hold until the next write to the same register. A halt written on an edge affects the ticks after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle strobe at the 32.768 kHz prescaler rate |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 = mode register, 1 = command register |
| wrData | input | 4 | Write data |
| busyIn | input | 1 | External busy level routed to the pin when code 111 is selected |
| pulseN | output | 1 | Active-low interval pulse pin |
| intFlag | output | 1 | Sticky interval flag |

## Verification
Interval ends, the pulse and the flag all take effect on the tick edge that completes an interval. They are visible a quarter clock after that edge, and the pulse clears after the next tick edge. A restart or a flag clear acts on its own write edge. Mode, halt and mute are registered on the write edge, so the pin responds right after it, while a halt only affects the ticks from the next edge on; busyIn passes through in the same cycle. A behavioural model in the bench applies these same latencies in its own arithmetic and is compared with both outputs a quarter period after every rising edge. Directed measurements of tick gaps between pulse starts check the periods, the uneven tenth sequence, halt/resume and restart.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [2:0] {
    PER_TENTH  = 3'b000,
    PER_ONE    = 3'b001,
    PER_TEN    = 3'b010,
    PER_THIRTY = 3'b011,
    PER_SIXTY  = 3'b100,
    PER_RSV5   = 3'b101,
    PER_RSV6   = 3'b110,
    PER_BUSY   = 3'b111
  } periodSel_e;

  typedef struct packed {
    logic tick;
    logic advance;
    logic restart;
    logic flagClr;
  } ctrlStrobes_t;

  localparam int BIT_HALT    = 0;
  localparam int BIT_RESTART = 1;
  localparam int BIT_MUTE    = 2;
  localparam int BIT_FLAGCLR = 3;
  localparam int BIT_ONESHOT = 3;
endpackage

// File: rtl/ipt_ctrl.sv
module ipt_ctrl
  import ipt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         wrEn,
  input  logic         wrSel,
  input  logic [3:0]   wrData,
  output ctrlStrobes_t strb,
  output periodSel_e   periodSel,
  output logic         oneShot,
  output logic         muteOut
);
  logic haltReg;
  logic modeWr;
  logic cmdWr;

  assign modeWr = wrEn & ~wrSel;
  assign cmdWr  = wrEn & wrSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodSel <= PER_TENTH;
      oneShot   <= 1'b0;
      haltReg   <= 1'b0;
      muteOut   <= 1'b0;
    end else begin
      if (modeWr) begin
        periodSel <= periodSel_e'(wrData[2:0]);
        oneShot   <= wrData[BIT_ONESHOT];
      end
      if (cmdWr) begin
        haltReg <= wrData[BIT_HALT];
        muteOut <= wrData[BIT_MUTE];
      end
    end
  end

  always_comb begin
    strb.tick    = tickEn;
    strb.advance = tickEn & ~haltReg;
    strb.restart = cmdWr & wrData[BIT_RESTART];
    strb.flagClr = cmdWr & wrData[BIT_FLAGCLR];
  end

  // R7: a halt written on one edge blocks counting from the next edge
  p_halt_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && wrData[BIT_HALT]) |=> !strb.advance);

  // R12: mode settings hold between writes
  p_mode_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(periodSel) && $stable(oneShot)));
endmodule

// File: rtl/ipt_datapath.sv
module ipt_datapath
  import ipt_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  input  periodSel_e   periodSel,
  input  logic         oneShot,
  input  logic         muteOut,
  input  logic         busyIn,
  output logic         pulseN,
  output logic         intFlag
);
  localparam int HALF = TICKS_PER_SEC / 2;
  localparam int CW   = $clog2(HALF);
  localparam int FIFTHS = 4;

  logic [CW-1:0] halfCnt;
  logic [CW-1:0] halfNext;
  logic          halfIdx;
  logic [3:0]    secUnits;
  logic [2:0]    secTens;
  logic          oneShotDone;
  logic          pulseActive;

  logic          advanceEff;
  logic          halfWrap;
  logic          secDone;
  logic          tenDone;
  logic          thirtyDone;
  logic          minuteDone;
  logic          tenthDone;
  logic          periodHit;
  logic          intervalEv;
  logic [FIFTHS-1:0] markHit;

  assign advanceEff = strb.advance & ~oneShotDone & ~strb.restart;
  assign halfWrap   = (halfCnt == CW'(HALF - 1));
  assign halfNext   = halfWrap ? '0 : halfCnt + 1'b1;

  for (genvar k = 1; k <= FIFTHS; k++) begin : g_mark
    localparam int MARK = (k * HALF) / 5;
    assign markHit[k-1] = (halfNext == CW'(MARK));
  end

  assign tenthDone  = (|markHit) | halfWrap;
  assign secDone    = halfWrap & halfIdx;
  assign tenDone    = secDone & (secUnits == 4'd9);
  assign thirtyDone = tenDone & ((secTens == 3'd2) || (secTens == 3'd5));
  assign minuteDone = tenDone & (secTens == 3'd5);

  always_comb begin
    case (periodSel)
      PER_TENTH:  periodHit = tenthDone;
      PER_ONE:    periodHit = secDone;
      PER_TEN:    periodHit = tenDone;
      PER_THIRTY: periodHit = thirtyDone;
      PER_SIXTY:  periodHit = minuteDone;
      default:    periodHit = 1'b0;
    endcase
  end

  assign intervalEv = advanceEff & periodHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt     <= '0;
      halfIdx     <= 1'b0;
      secUnits    <= '0;
      secTens     <= '0;
      oneShotDone <= 1'b0;
      pulseActive <= 1'b0;
      intFlag     <= 1'b0;
    end else begin
      if (strb.restart) begin
        halfCnt     <= '0;
        halfIdx     <= 1'b0;
        secUnits    <= '0;
        secTens     <= '0;
        oneShotDone <= 1'b0;
        pulseActive <= 1'b0;
      end else begin
        if (advanceEff) begin
          halfCnt <= halfNext;
          if (halfWrap) halfIdx <= ~halfIdx;
          if (secDone) begin
            secUnits <= (secUnits == 4'd9) ? 4'd0 : secUnits + 4'd1;
            if (secUnits == 4'd9)
              secTens <= (secTens == 3'd5) ? 3'd0 : secTens + 3'd1;
          end
          if (intervalEv && oneShot) oneShotDone <= 1'b1;
        end
        if (strb.tick) pulseActive <= intervalEv;
      end
      if (intervalEv) intFlag <= 1'b1;
      else if (strb.flagClr) intFlag <= 1'b0;
    end
  end

  always_comb begin
    if (muteOut) pulseN = 1'b1;
    else if (periodSel == PER_BUSY) pulseN = ~busyIn;
    else pulseN = ~pulseActive;
  end

  // R2: seconds digits stay in decimal range
  p_sec_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (secUnits <= 4'd9) && (secTens <= 3'd5));

  // R4: a pulse starts only on a tick edge and lasts until the next tick
  p_pulse_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseActive) |-> $past(strb.tick));
  p_pulse_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && !strb.tick && !strb.restart) |=> pulseActive);

  // R6: no new pulse while a one-shot hold is in force
  p_oneshot_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotDone && !strb.restart) |=> !$rose(pulseActive));

  // R7: the count is frozen when the control withholds advance
  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.restart) |=>
      ($stable(halfCnt) && $stable(halfIdx) && $stable(secUnits) && $stable(secTens)));

  // R10: the flag only drops on a clear request
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && !strb.flagClr) |=> intFlag);

  // R11: busy selection never raises the flag
  p_busy_no_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((periodSel == PER_BUSY) && !intFlag) |=> !intFlag);
endmodule

// File: rtl/interval_pulse_timer.sv
module interval_pulse_timer
  import ipt_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [3:0] wrData,
  input  logic       busyIn,
  output logic       pulseN,
  output logic       intFlag
);
  ctrlStrobes_t strb;
  periodSel_e   periodSel;
  logic         oneShot;
  logic         muteOut;

  ipt_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrData    (wrData),
    .strb      (strb),
    .periodSel (periodSel),
    .oneShot   (oneShot),
    .muteOut   (muteOut)
  );

  ipt_datapath #(.TICKS_PER_SEC(TICKS_PER_SEC)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .periodSel (periodSel),
    .oneShot   (oneShot),
    .muteOut   (muteOut),
    .busyIn    (busyIn),
    .pulseN    (pulseN),
    .intFlag   (intFlag)
  );
endmodule

// File: tb/interval_pulse_timer_tb_top.sv
module interval_pulse_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 44;
  localparam int H          = TPS / 2;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [3:0] wrData = 4'd0;
  logic busyIn = 1'b0;
  logic pulseN;
  logic intFlag;

  int nChecks = 0;
  int nFail = 0;
  int tickNum = 0;
  int lowSamples = 0;
  int lowRun = 0;
  int lastLowWidth = 0;
  logic prevPin = 1'b1;
  int pulseTicks[$];
  string curReq = "R12";

  // model state
  int mCode = 0;
  bit mOne = 0, mHalt = 0, mMute = 0, mDone = 0, mPulse = 0, mFlag = 0;
  int mE = 0;

  interval_pulse_timer #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .busyIn(busyIn), .pulseN(pulseN), .intFlag(intFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rstN) tickEn <= 1'b0;
    else tickEn <= ~tickEn;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit isEnd(input int e, input int code);
    int p;
    case (code)
      0: begin
        p = e % H;
        if (p == 0) return 1'b1;
        for (int k = 1; k <= 4; k++) if ((k * H) / 5 == p) return 1'b1;
        return 1'b0;
      end
      1: return (e % TPS) == 0;
      2: return (e % (10 * TPS)) == 0;
      3: return (e % (30 * TPS)) == 0;
      4: return e == 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int lenOf(input int k);
    return (k * H) / 5 - ((k - 1) * H) / 5;
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    bit rs, clr, adv, ev;
    if (!rstN) begin
      mCode = 0; mOne = 0; mHalt = 0; mMute = 0; mDone = 0;
      mPulse = 0; mFlag = 0; mE = 0;
    end else begin
      rs  = wrEn && wrSel && wrData[1];
      clr = wrEn && wrSel && wrData[3];
      adv = tickEn && !mHalt && !mDone && !rs;
      ev  = 1'b0;
      if (rs) begin
        mE = 0; mDone = 0; mPulse = 0;
      end else if (tickEn) begin
        if (adv) begin
          mE = (mE + 1) % (60 * TPS);
          ev = isEnd(mE, mCode);
          if (ev && mOne) mDone = 1;
        end
        mPulse = ev;
      end
      if (ev) mFlag = 1;
      else if (clr) mFlag = 0;
      if (wrEn && !wrSel) begin mCode = wrData[2:0]; mOne = wrData[3]; end
      if (wrEn && wrSel) begin mHalt = wrData[0]; mMute = wrData[2]; end
      if (tickEn) tickNum++;
    end
  end

  // per-clock comparison and pulse bookkeeping
  always @(posedge clk) begin
    bit expPin;
    #(CLK_PERIOD/4);
    if (rstN) begin
      expPin = mMute ? 1'b1 : ((mCode == 7) ? !busyIn : !mPulse);
      chk({curReq, " pin"}, int'(pulseN), int'(expPin));
      chk({curReq, " flag"}, int'(intFlag), int'(mFlag));
      if (prevPin && !pulseN) pulseTicks.push_back(tickNum);
      if (!pulseN) begin
        lowRun++; lowSamples++;
      end else if (!prevPin) begin
        lastLowWidth = lowRun; lowRun = 0;
      end
      prevPin = pulseN;
    end
  end

  task automatic wr(input bit sel, input logic [3:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 4'd0;
  endtask

  task automatic waitPulses(input int n, input string req);
    int cnt = 0;
    while (pulseTicks.size() < n && cnt < 2 * 60 * TPS * 2 + 200) begin
      @(negedge clk); cnt++;
    end
    chk({req, " pulse arrived"}, int'(pulseTicks.size() >= n), 1);
  endtask

  task automatic waitSec(input int halfSecs);
    repeat (halfSecs * H * 2 + 6) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    int ref0, sum;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset pin", int'(pulseN), 1);
    chk("R1 reset flag", int'(intFlag), 0);

    // R3 uneven tenth intervals
    curReq = "R3";
    wr(1'b1, 4'b0010);
    pulseTicks.delete();
    waitPulses(6, "R3");
    sum = 0;
    for (int j = 1; j <= 5; j++) begin
      chk("R3 tenth gap", pulseTicks[j] - pulseTicks[j-1], lenOf((j % 5) + 1));
      sum += pulseTicks[j] - pulseTicks[j-1];
    end
    chk("R3 five tenths equal half second", sum, H);
    repeat (6) @(negedge clk);
    // R4 pulse width is one tick period (two clocks here)
    chk("R4 low width", lastLowWidth, 2);

    // R2 and R5 periods in repeat mode
    curReq = "R2";
    for (int c = 1; c <= 4; c++) begin
      int mult;
      mult = (c == 1) ? 1 : (c == 2) ? 10 : (c == 3) ? 30 : 60;
      wr(1'b0, 4'(c));
      wr(1'b1, 4'b0010);
      pulseTicks.delete();
      waitPulses(2, "R5");
      chk("R2 period ticks", pulseTicks[1] - pulseTicks[0], mult * TPS);
    end

    // R5 repeat count
    curReq = "R5";
    wr(1'b0, 4'b0001);
    wr(1'b1, 4'b0010);
    pulseTicks.delete();
    waitSec(7);
    chk("R5 repeat pulses in 3.5 s", pulseTicks.size(), 3);

    // R8 restart mid-period
    curReq = "R8";
    repeat (40) @(negedge clk);
    wr(1'b1, 4'b0010);
    ref0 = tickNum;
    pulseTicks.delete();
    waitPulses(1, "R8");
    chk("R8 full period after restart", pulseTicks[0] - ref0, TPS);

    // R7 halt and resume keeps elapsed part
    curReq = "R7";
    pulseTicks.delete();
    waitPulses(1, "R7");
    repeat (20) @(negedge clk);
    wr(1'b1, 4'b0001);
    repeat (38) @(negedge clk);
    wr(1'b1, 4'b0000);
    waitPulses(2, "R7");
    chk("R7 t1+t2 plus halted ticks", pulseTicks[1] - pulseTicks[0], TPS + 20);

    // R6 one-shot
    curReq = "R6";
    wr(1'b0, 4'b1001);
    wr(1'b1, 4'b1010);
    pulseTicks.delete();
    waitSec(6);
    chk("R6 single pulse", pulseTicks.size(), 1);
    wr(1'b1, 4'b1000);
    waitSec(2);
    chk("R6 flag stays clear while held", int'(intFlag), 0);
    wr(1'b1, 4'b0010);
    pulseTicks.delete();
    waitSec(4);
    chk("R6 restart releases hold", pulseTicks.size(), 1);

    // R10 flag set and clear
    curReq = "R10";
    wr(1'b0, 4'b0001);
    wr(1'b1, 4'b1010);
    pulseTicks.delete();
    waitPulses(1, "R10");
    chk("R10 flag set", int'(intFlag), 1);
    repeat (4) @(negedge clk);
    wr(1'b1, 4'b1000);
    chk("R10 flag cleared", int'(intFlag), 0);
    waitPulses(2, "R10");
    chk("R10 flag set again", int'(intFlag), 1);

    // R9 mute
    curReq = "R9";
    wr(1'b1, 4'b1000);
    wr(1'b1, 4'b0110);
    ref0 = lowSamples;
    waitSec(5);
    chk("R9 pin stays high", lowSamples - ref0, 0);
    chk("R9 flag still set", int'(intFlag), 1);
    wr(1'b1, 4'b0000);

    // R11 busy routing
    curReq = "R11";
    wr(1'b0, 4'b0111);
    wr(1'b1, 4'b1000);
    busyIn = 1'b1;
    #1;
    chk("R11 busy drives pin low", int'(pulseN), 0);
    @(negedge clk);
    busyIn = 1'b0;
    #1;
    chk("R11 idle drives pin high", int'(pulseN), 1);
    waitSec(5);
    chk("R11 no flag", int'(intFlag), 0);
    wr(1'b1, 4'b0100);
    busyIn = 1'b1;
    #1;
    chk("R9 mute overrides busy", int'(pulseN), 1);
    @(negedge clk);
    busyIn = 1'b0;
    wr(1'b1, 4'b0000);

    // R2 reserved code
    curReq = "R2";
    wr(1'b0, 4'b0101);
    wr(1'b1, 4'b1010);
    pulseTicks.delete();
    waitSec(5);
    chk("R2 reserved code no pulses", pulseTicks.size(), 0);
    chk("R2 reserved code no flag", int'(intFlag), 0);

    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule